// File: doc/BRIEF.md
# Host PHY Clock-Path Configuration Sequencer

This block reconfigures the clocking path of a storage-card host PHY each time the bus clock frequency or the bus speed mode changes. A single start pulse captures the target frequency, the speed-mode code, the per-mode tap values, the loop trim and drive-strength codes, the clock-buffer select and a PHY variant flag. The sequencer then steps through a fixed series of single-cycle writes to the PHY control fields. It first stops the card clock and disables the delay-locked loop (DLL). It then restarts the clock and programs the output tap.

For fast modes the block locks the DLL. For slower modes it routes the clock through the bypass delay chain and programs the input tap under a guarded change window. Either path ends with the clock-buffer select and a one-cycle done pulse. The analog loop is modelled by a ready input. A loop that never reports ready causes a bounded timeout and a sticky error, and no done pulse is given.

Top module: `phy_clkpath_seq`

## Requirements
- R1: After reset every control output, busy, done and the error flag are 0.
- R2: A start pulse accepted in idle raises busy at the next edge. One cycle later the card clock enable and the loop enable are both 0. One cycle after that the card clock enable is 1 again.
- R3: One cycle after the clock restart, the output tap enable is 1 and the output tap select holds the captured 4-bit value.
- R4: The strobe select is written in the same cycle as the output tap, and only when the mode code is 10 (the top double-rate mode). With the variant flag at 1 only bits 3:0 are written and bits 7:4 keep their value. With the flag at 0 all 8 bits are written.
- R5: The loop path is taken only when the mode code is above 4 and the frequency is at least 50,000,000 Hz. Every other case takes the delay-chain path.
- R6: On the loop path the TX and RX delay-chain selects are cleared, and the trim and drive-strength fields are written. With the variant flag at 1, the {half-rate, mid-rate} select pair is {0,0} for 200 MHz, {0,1} for 100 MHz and {1,0} for any other frequency. The loop enable rises one cycle after these writes.
- R7: With the variant flag at 0 the 3-bit frequency select becomes 0 for 200 MHz and 4 for any other frequency. Each variant leaves the other variant's frequency fields unchanged.
- R8: After the loop enable rises, the block waits for ready. If ready is absent for TIMEOUT_CYC wait cycles, the sticky error flag rises, busy drops and no done pulse is given. The next accepted start clears the flag.
- R9: On the delay-chain path the TX and RX selects are set. On each of the following cycles in turn, the change window is raised, the 5-bit input tap is written and the window is lowered. The input tap never changes outside the window.
- R10: The clock-buffer select is written last, in the cycle of a one-cycle done pulse, and busy is 0 in that cycle.
- R11: A start pulse that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, captures all settings |
| freq_hz_i | input | 32 | Target bus clock in Hz |
| mode_i | input | 4 | Speed-mode code, 0..10 in rising order |
| otap_i | input | 4 | Output tap for the mode |
| itap_i | input | 5 | Input tap for the mode |
| strb_i | input | 8 | Strobe select for the top mode |
| trim_i | input | 4 | Loop charge-pump trim |
| drv_i | input | 3 | Loop drive-strength code |
| clkbuf_i | input | 3 | Clock-buffer select |
| narrow_i | input | 1 | Variant: 1 = two-bit rate pair and 4-bit strobe |
| dll_ready_i | input | 1 | Loop locked status |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky lock timeout flag |
| card_clk_en_o | output | 1 | Card clock enable |
| dll_en_o | output | 1 | Loop enable |
| otap_en_o | output | 1 | Output tap enable |
| otap_sel_o | output | 4 | Output tap select |
| strb_sel_o | output | 8 | Strobe select |
| sel50_o | output | 1 | Half-rate loop select |
| sel100_o | output | 1 | Mid-rate loop select |
| freqsel_o | output | 3 | Loop frequency select, wide variant |
| dly_tx_o | output | 1 | TX delay-chain select |
| dly_rx_o | output | 1 | RX delay-chain select |
| itap_sel_o | output | 5 | Input tap select |
| itap_win_o | output | 1 | Input tap change window |
| trim_o | output | 4 | Loop trim field |
| drv_o | output | 3 | Loop drive-strength field |
| clkbuf_o | output | 3 | Clock-buffer select field |

## Verification
Count the start edge as edge 0. Busy is visible after edge 0. The stop writes follow edge 1 and the clock restart edge 2. The output tap and strobe writes follow edge 3. The path writes follow edge 4. On the delay chain, the window opens after edge 5, the input tap is written after edge 6, the window closes after edge 7 and done comes after edge 8. On the loop path, the loop enable follows edge 5. Done comes two edges after ready is seen, or the error rises after edge 5 + TIMEOUT_CYC. The driver records the start cycle and pushes the cycle in which done or the error is due, together with the full expected field set. The monitor samples on the falling edge and compares both the arrival cycle and the fields. The driver also samples each intermediate step at its own cycle.

// File: rtl/phy_clkpath_pkg.sv
package phy_clkpath_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_STOP,
    ST_RESTART,
    ST_OTAP,
    ST_DLL_CFG,
    ST_DLL_EN,
    ST_DLL_WAIT,
    ST_DC_SEL,
    ST_WIN_OPEN,
    ST_ITAP,
    ST_WIN_CLOSE,
    ST_CLKBUF
  } seq_state_e;

  // Speed-mode codes rise with bus speed; decisions compare against these.
  localparam int unsigned MODE_LAST_SLOW = 4;
  localparam int unsigned MODE_TOP       = 10;

  localparam int unsigned HZ_FULL = 200_000_000;
  localparam int unsigned HZ_MID  = 100_000_000;
  localparam int unsigned HZ_MIN_LOOP = 50_000_000;

  localparam int unsigned FSEL_FULL  = 0;
  localparam int unsigned FSEL_OTHER = 4;

endpackage

// File: rtl/phy_clkpath_decode.sv
module phy_clkpath_decode
  import phy_clkpath_pkg::*;
#(
  parameter int FREQ_W    = 32,
  parameter int MODE_W    = 4,
  parameter int FREQSEL_W = 3
) (
  input  logic [FREQ_W-1:0]    freq_i,
  input  logic [MODE_W-1:0]    mode_i,
  output logic                 use_dll_o,
  output logic                 top_mode_o,
  output logic                 half_o,
  output logic                 mid_o,
  output logic [FREQSEL_W-1:0] fsel_o
);

  logic is_full;
  logic is_mid;

  always_comb begin
    is_full    = (freq_i == FREQ_W'(HZ_FULL));
    is_mid     = (freq_i == FREQ_W'(HZ_MID));
    use_dll_o  = (mode_i > MODE_W'(MODE_LAST_SLOW)) &&
                 (freq_i >= FREQ_W'(HZ_MIN_LOOP));
    top_mode_o = (mode_i == MODE_W'(MODE_TOP));
    half_o     = !is_full && !is_mid;
    mid_o      = is_mid;
    fsel_o     = is_full ? FREQSEL_W'(FSEL_FULL) : FREQSEL_W'(FSEL_OTHER);
  end

endmodule

// File: rtl/phy_clkpath_timer.sv
module phy_clkpath_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  output logic expired_o
);

  localparam int CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign expired_o = (cnt_q == CNT_W'(LIMIT - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)
      cnt_d = '0;
    else if (en_i && !expired_o)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

endmodule

// File: rtl/phy_clkpath_fsm.sv
module phy_clkpath_fsm
  import phy_clkpath_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       use_dll_i,
  input  logic       ready_i,
  input  logic       expired_i,
  output seq_state_e state_o,
  output logic       accept_o
);

  seq_state_e state_q;
  seq_state_e state_d;

  assign state_o  = state_q;
  assign accept_o = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:      if (start_i) state_d = ST_STOP;
      ST_STOP:      state_d = ST_RESTART;
      ST_RESTART:   state_d = ST_OTAP;
      ST_OTAP:      state_d = use_dll_i ? ST_DLL_CFG : ST_DC_SEL;
      ST_DLL_CFG:   state_d = ST_DLL_EN;
      ST_DLL_EN:    state_d = ST_DLL_WAIT;
      ST_DLL_WAIT: begin
        if (ready_i)        state_d = ST_CLKBUF;
        else if (expired_i) state_d = ST_IDLE;
      end
      ST_DC_SEL:    state_d = ST_WIN_OPEN;
      ST_WIN_OPEN:  state_d = ST_ITAP;
      ST_ITAP:      state_d = ST_WIN_CLOSE;
      ST_WIN_CLOSE: state_d = ST_CLKBUF;
      ST_CLKBUF:    state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      state_q <= ST_IDLE;
    else
      state_q <= state_d;
  end

endmodule

// File: rtl/phy_clkpath_seq.sv
module phy_clkpath_seq
  import phy_clkpath_pkg::*;
#(
  parameter int FREQ_W        = 32,
  parameter int MODE_W        = 4,
  parameter int OTAP_W        = 4,
  parameter int ITAP_W        = 5,
  parameter int STRB_W        = 8,
  parameter int STRB_NARROW_W = 4,
  parameter int TRIM_W        = 4,
  parameter int DRV_W         = 3,
  parameter int CLKBUF_W      = 3,
  parameter int FREQSEL_W     = 3,
  parameter int TIMEOUT_CYC   = 1024
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [FREQ_W-1:0]    freq_hz_i,
  input  logic [MODE_W-1:0]    mode_i,
  input  logic [OTAP_W-1:0]    otap_i,
  input  logic [ITAP_W-1:0]    itap_i,
  input  logic [STRB_W-1:0]    strb_i,
  input  logic [TRIM_W-1:0]    trim_i,
  input  logic [DRV_W-1:0]     drv_i,
  input  logic [CLKBUF_W-1:0]  clkbuf_i,
  input  logic                 narrow_i,
  input  logic                 dll_ready_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 err_o,
  output logic                 card_clk_en_o,
  output logic                 dll_en_o,
  output logic                 otap_en_o,
  output logic [OTAP_W-1:0]    otap_sel_o,
  output logic [STRB_W-1:0]    strb_sel_o,
  output logic                 sel50_o,
  output logic                 sel100_o,
  output logic [FREQSEL_W-1:0] freqsel_o,
  output logic                 dly_tx_o,
  output logic                 dly_rx_o,
  output logic [ITAP_W-1:0]    itap_sel_o,
  output logic                 itap_win_o,
  output logic [TRIM_W-1:0]    trim_o,
  output logic [DRV_W-1:0]     drv_o,
  output logic [CLKBUF_W-1:0]  clkbuf_o
);

  // ---------------- captured settings ----------------
  logic [FREQ_W-1:0]   c_freq;
  logic [MODE_W-1:0]   c_mode;
  logic [OTAP_W-1:0]   c_otap;
  logic [ITAP_W-1:0]   c_itap;
  logic [STRB_W-1:0]   c_strb;
  logic [TRIM_W-1:0]   c_trim;
  logic [DRV_W-1:0]    c_drv;
  logic [CLKBUF_W-1:0] c_clkbuf;
  logic                c_narrow;

  seq_state_e state;
  logic       accept;
  logic       use_dll;
  logic       top_mode;
  logic       dec_half;
  logic       dec_mid;
  logic [FREQSEL_W-1:0] dec_fsel;
  logic       expired;
  logic       tmr_clr;
  logic       tmr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_freq   <= '0;
      c_mode   <= '0;
      c_otap   <= '0;
      c_itap   <= '0;
      c_strb   <= '0;
      c_trim   <= '0;
      c_drv    <= '0;
      c_clkbuf <= '0;
      c_narrow <= 1'b0;
    end else if (accept) begin
      c_freq   <= freq_hz_i;
      c_mode   <= mode_i;
      c_otap   <= otap_i;
      c_itap   <= itap_i;
      c_strb   <= strb_i;
      c_trim   <= trim_i;
      c_drv    <= drv_i;
      c_clkbuf <= clkbuf_i;
      c_narrow <= narrow_i;
    end
  end

  // ---------------- sub-blocks ----------------
  phy_clkpath_decode #(
    .FREQ_W    (FREQ_W),
    .MODE_W    (MODE_W),
    .FREQSEL_W (FREQSEL_W)
  ) u_decode (
    .freq_i     (c_freq),
    .mode_i     (c_mode),
    .use_dll_o  (use_dll),
    .top_mode_o (top_mode),
    .half_o     (dec_half),
    .mid_o      (dec_mid),
    .fsel_o     (dec_fsel)
  );

  phy_clkpath_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .use_dll_i (use_dll),
    .ready_i   (dll_ready_i),
    .expired_i (expired),
    .state_o   (state),
    .accept_o  (accept)
  );

  assign tmr_clr = (state == ST_DLL_EN);
  assign tmr_en  = (state == ST_DLL_WAIT);

  phy_clkpath_timer #(
    .LIMIT (TIMEOUT_CYC)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (tmr_clr),
    .en_i      (tmr_en),
    .expired_o (expired)
  );

  // ---------------- strobe write mask per variant ----------------
  logic [STRB_W-1:0] strb_q;
  logic [STRB_W-1:0] strb_wr;

  for (genvar b = 0; b < STRB_W; b++) begin : g_strb
    if (b < STRB_NARROW_W) begin : g_low
      assign strb_wr[b] = c_strb[b];
    end else begin : g_high
      assign strb_wr[b] = c_narrow ? strb_q[b] : c_strb[b];
    end
  end

  // ---------------- output field registers ----------------
  logic                 clk_en_q,  clk_en_d;
  logic                 dll_en_q,  dll_en_d;
  logic                 otap_en_q, otap_en_d;
  logic [OTAP_W-1:0]    otap_q,    otap_d;
  logic [STRB_W-1:0]    strb_d;
  logic                 half_q,    half_d;
  logic                 mid_q,     mid_d;
  logic [FREQSEL_W-1:0] fsel_q,    fsel_d;
  logic                 dly_q,     dly_d;
  logic [ITAP_W-1:0]    itap_q,    itap_d;
  logic                 win_q,     win_d;
  logic [TRIM_W-1:0]    trim_q,    trim_d;
  logic [DRV_W-1:0]     drv_q,     drv_d;
  logic [CLKBUF_W-1:0]  cb_q,      cb_d;
  logic                 done_q,    done_d;
  logic                 err_q,     err_d;

  always_comb begin
    clk_en_d  = clk_en_q;
    dll_en_d  = dll_en_q;
    otap_en_d = otap_en_q;
    otap_d    = otap_q;
    strb_d    = strb_q;
    half_d    = half_q;
    mid_d     = mid_q;
    fsel_d    = fsel_q;
    dly_d     = dly_q;
    itap_d    = itap_q;
    win_d     = win_q;
    trim_d    = trim_q;
    drv_d     = drv_q;
    cb_d      = cb_q;
    done_d    = 1'b0;
    err_d     = err_q;
    case (state)
      ST_IDLE: if (start_i) err_d = 1'b0;
      ST_STOP: begin
        clk_en_d = 1'b0;
        dll_en_d = 1'b0;
      end
      ST_RESTART: clk_en_d = 1'b1;
      ST_OTAP: begin
        otap_en_d = 1'b1;
        otap_d    = c_otap;
        if (top_mode) strb_d = strb_wr;
      end
      ST_DLL_CFG: begin
        dly_d = 1'b0;
        if (c_narrow) begin
          half_d = dec_half;
          mid_d  = dec_mid;
        end else begin
          fsel_d = dec_fsel;
        end
        trim_d = c_trim;
        drv_d  = c_drv;
      end
      ST_DLL_EN:    dll_en_d = 1'b1;
      ST_DLL_WAIT:  if (!dll_ready_i && expired) err_d = 1'b1;
      ST_DC_SEL:    dly_d = 1'b1;
      ST_WIN_OPEN:  win_d = 1'b1;
      ST_ITAP:      itap_d = c_itap;
      ST_WIN_CLOSE: win_d = 1'b0;
      ST_CLKBUF: begin
        cb_d   = c_clkbuf;
        done_d = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_en_q  <= 1'b0;
      dll_en_q  <= 1'b0;
      otap_en_q <= 1'b0;
      otap_q    <= '0;
      strb_q    <= '0;
      half_q    <= 1'b0;
      mid_q     <= 1'b0;
      fsel_q    <= '0;
      dly_q     <= 1'b0;
      itap_q    <= '0;
      win_q     <= 1'b0;
      trim_q    <= '0;
      drv_q     <= '0;
      cb_q      <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      clk_en_q  <= clk_en_d;
      dll_en_q  <= dll_en_d;
      otap_en_q <= otap_en_d;
      otap_q    <= otap_d;
      strb_q    <= strb_d;
      half_q    <= half_d;
      mid_q     <= mid_d;
      fsel_q    <= fsel_d;
      dly_q     <= dly_d;
      itap_q    <= itap_d;
      win_q     <= win_d;
      trim_q    <= trim_d;
      drv_q     <= drv_d;
      cb_q      <= cb_d;
      done_q    <= done_d;
      err_q     <= err_d;
    end
  end

  assign busy_o        = (state != ST_IDLE);
  assign done_o        = done_q;
  assign err_o         = err_q;
  assign card_clk_en_o = clk_en_q;
  assign dll_en_o      = dll_en_q;
  assign otap_en_o     = otap_en_q;
  assign otap_sel_o    = otap_q;
  assign strb_sel_o    = strb_q;
  assign sel50_o       = half_q;
  assign sel100_o      = mid_q;
  assign freqsel_o     = fsel_q;
  assign dly_tx_o      = dly_q;
  assign dly_rx_o      = dly_q;
  assign itap_sel_o    = itap_q;
  assign itap_win_o    = win_q;
  assign trim_o        = trim_q;
  assign drv_o         = drv_q;
  assign clkbuf_o      = cb_q;

endmodule

// File: rtl/phy_clkpath_chk.sv
module phy_clkpath_chk #(
  parameter int ITAP_W   = 5,
  parameter int TRIM_W   = 4,
  parameter int DRV_W    = 3,
  parameter int CLKBUF_W = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busy_o,
  input logic                done_o,
  input logic                err_o,
  input logic                card_clk_en_o,
  input logic                dll_en_o,
  input logic [ITAP_W-1:0]   itap_sel_o,
  input logic                itap_win_o,
  input logic [TRIM_W-1:0]   trim_o,
  input logic [DRV_W-1:0]    drv_o,
  input logic [CLKBUF_W-1:0] clkbuf_o
);

  p_stop_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |=> (!card_clk_en_o && !dll_en_o));

  p_trim_settled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dll_en_o) |-> ($stable(trim_o) && $stable(drv_o)));

  p_timeout_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> (!done_o && !busy_o));

  p_itap_in_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(itap_sel_o) |-> (itap_win_o && $past(itap_win_o)));

  p_clkbuf_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clkbuf_o) |-> done_o);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

bind phy_clkpath_seq phy_clkpath_chk #(
  .ITAP_W   (ITAP_W),
  .TRIM_W   (TRIM_W),
  .DRV_W    (DRV_W),
  .CLKBUF_W (CLKBUF_W)
) u_chk (.*);

// File: tb/phy_clkpath_seq_tb_top.sv
module phy_clkpath_seq_tb_top;

  localparam int T_OUT = 16;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [31:0] freq_hz_i;
  logic [3:0]  mode_i;
  logic [3:0]  otap_i;
  logic [4:0]  itap_i;
  logic [7:0]  strb_i;
  logic [3:0]  trim_i;
  logic [2:0]  drv_i;
  logic [2:0]  clkbuf_i;
  logic        narrow_i;
  logic        dll_ready_i;
  logic        busy_o, done_o, err_o, card_clk_en_o, dll_en_o, otap_en_o;
  logic [3:0]  otap_sel_o;
  logic [7:0]  strb_sel_o;
  logic        sel50_o, sel100_o;
  logic [2:0]  freqsel_o;
  logic        dly_tx_o, dly_rx_o;
  logic [4:0]  itap_sel_o;
  logic        itap_win_o;
  logic [3:0]  trim_o;
  logic [2:0]  drv_o;
  logic [2:0]  clkbuf_o;

  int rdy_mode;   // 0: ready follows loop enable, 1: never, 2: level below
  logic rdy_lvl;
  assign dll_ready_i = (rdy_mode == 0) ? dll_en_o : rdy_lvl;

  phy_clkpath_seq #(.TIMEOUT_CYC(T_OUT)) dut_i (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int cyc;
  int n_vec;
  int n_bad;
  bit finished;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  typedef struct {
    int        due;
    bit        is_err;
    logic      card, dll, oen, half, mid, dly;
    logic [3:0] otap, trim;
    logic [7:0] strb;
    logic [2:0] fsel, drv, cb;
    logic [4:0] itap;
  } exp_t;

  exp_t q[$];
  exp_t m;   // shadow of expected field state

  // ---------------- monitor ----------------
  logic err_prev;
  always @(negedge clk) begin
    if (!rst_n) begin
      err_prev = 1'b0;
    end else begin
      if (done_o || (err_o && !err_prev)) begin
        if (q.size() == 0) begin
          chk("R10", "unexpected completion", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(e.is_err ? "R8" : "R10", "completion cycle", cyc, e.due);
          chk("R8", "done vs timeout", {31'd0, done_o}, {31'd0, !e.is_err});
          chk("R8", "error flag", {31'd0, err_o}, {31'd0, e.is_err});
          chk("R10", "busy at completion", {31'd0, busy_o}, 32'd0);
          chk("R2", "card clock", {31'd0, card_clk_en_o}, {31'd0, e.card});
          chk("R6", "loop enable", {31'd0, dll_en_o}, {31'd0, e.dll});
          chk("R3", "otap enable", {31'd0, otap_en_o}, {31'd0, e.oen});
          chk("R3", "otap select", {28'd0, otap_sel_o}, {28'd0, e.otap});
          chk("R4", "strobe", {24'd0, strb_sel_o}, {24'd0, e.strb});
          chk("R6", "rate pair", {30'd0, sel50_o, sel100_o}, {30'd0, e.half, e.mid});
          chk("R7", "freq select", {29'd0, freqsel_o}, {29'd0, e.fsel});
          chk("R9", "delay chain", {30'd0, dly_tx_o, dly_rx_o}, {30'd0, e.dly, e.dly});
          chk("R9", "itap", {27'd0, itap_sel_o}, {27'd0, e.itap});
          chk("R6", "trim", {28'd0, trim_o}, {28'd0, e.trim});
          chk("R6", "drive", {29'd0, drv_o}, {29'd0, e.drv});
          chk("R10", "clkbuf", {29'd0, clkbuf_o}, {29'd0, e.cb});
        end
      end
      err_prev = err_o;
    end
  end

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // ---------------- driver ----------------
  task automatic run_seq(input int mode, input int unsigned freq, input bit narrow,
                         input logic [3:0] otap, input logic [4:0] itap,
                         input logic [7:0] strb, input logic [3:0] trim,
                         input logic [2:0] drv, input logic [2:0] cb,
                         input int rdy, input bit poke);
    int s;
    bit use_dll;
    exp_t e;
    rdy_mode = rdy;
    rdy_lvl  = 1'b0;
    mode_i = 4'(mode); freq_hz_i = freq; narrow_i = narrow;
    otap_i = otap; itap_i = itap; strb_i = strb; trim_i = trim;
    drv_i = drv; clkbuf_i = cb;
    start_i = 1'b1;
    s = cyc;
    // expected model from the requirements (R3..R10)
    use_dll = (mode > 4) && (freq >= 50_000_000);
    m.card = 1'b1;
    m.oen  = 1'b1;
    m.otap = otap;
    if (mode == 10) begin
      if (narrow) m.strb[3:0] = strb[3:0];
      else        m.strb      = strb;
    end
    if (use_dll) begin
      m.dly = 1'b0;
      if (narrow) begin
        m.half = !(freq == 200_000_000 || freq == 100_000_000);
        m.mid  = (freq == 100_000_000);
      end else begin
        m.fsel = (freq == 200_000_000) ? 3'd0 : 3'd4;
      end
      m.trim = trim;
      m.drv  = drv;
      m.dll  = 1'b1;
    end else begin
      m.dll  = 1'b0;
      m.dly  = 1'b1;
      m.itap = itap;
    end
    e = m;
    e.is_err = use_dll && (rdy == 1);
    if (!e.is_err) begin
      m.cb = cb;
      e.cb = cb;
    end
    if (!use_dll)      e.due = s + 9;
    else if (rdy == 0) e.due = s + 8;
    else if (rdy == 1) e.due = s + 6 + T_OUT;
    else               e.due = s + 12;
    q.push_back(e);

    @(negedge clk);
    start_i = 1'b0;
    chk("R2", "busy after start", {31'd0, busy_o}, 32'd1);
    chk("R8", "error cleared on start", {31'd0, err_o}, 32'd0);
    wait_to(s + 2);
    chk("R2", "stop step", {30'd0, card_clk_en_o, dll_en_o}, 32'd0);
    wait_to(s + 3);
    chk("R2", "clock restart", {31'd0, card_clk_en_o}, 32'd1);
    if (poke) begin
      // R11: a second start while busy, with other settings
      start_i = 1'b1; mode_i = 4'd0; freq_hz_i = 32'd1;
      itap_i = ~itap; clkbuf_i = ~cb; otap_i = ~otap;
    end
    wait_to(s + 4);
    start_i = 1'b0;
    chk("R3", "otap step", {27'd0, otap_en_o, otap_sel_o}, {27'd0, 1'b1, otap});
    wait_to(s + 5);
    if (use_dll) begin
      chk("R6", "loop cfg step", {23'd0, dly_tx_o, dly_rx_o, dll_en_o, trim_o, drv_o},
          {23'd0, 1'b0, 1'b0, 1'b0, trim, drv});
      wait_to(s + 6);
      chk("R6", "loop enable step", {31'd0, dll_en_o}, 32'd1);
      if (rdy == 2) begin
        wait_to(s + 10);
        chk("R8", "still waiting", {31'd0, busy_o}, 32'd1);
        rdy_lvl = 1'b1;
      end
    end else begin
      chk("R9", "chain select step", {29'd0, dly_tx_o, dly_rx_o, itap_win_o}, {29'd0, 3'b110});
      wait_to(s + 6);
      chk("R9", "window open", {31'd0, itap_win_o}, 32'd1);
      wait_to(s + 7);
      chk("R9", "itap write", {26'd0, itap_win_o, itap_sel_o}, {26'd0, 1'b1, itap});
      wait_to(s + 8);
      chk("R9", "window closed", {31'd0, itap_win_o}, 32'd0);
    end
    wait_to(e.due + 2);
    chk("R10", "done is one pulse", {31'd0, done_o}, 32'd0);
    rdy_lvl = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; freq_hz_i = '0; mode_i = '0; otap_i = '0;
    itap_i = '0; strb_i = '0; trim_i = '0; drv_i = '0; clkbuf_i = '0;
    narrow_i = 1'b0; rdy_mode = 1; rdy_lvl = 1'b0;
    cyc = 0; n_vec = 0; n_bad = 0; finished = 0;
    m = '{default: '0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset outputs",
        {busy_o, done_o, err_o, card_clk_en_o, dll_en_o, otap_en_o, otap_sel_o,
         strb_sel_o, sel50_o, sel100_o, freqsel_o, dly_tx_o, dly_rx_o, itap_win_o},
        '0);
    chk("R1", "reset fields", {itap_sel_o, trim_o, drv_o, clkbuf_o}, '0);

    // R9: slow legacy mode takes the delay chain
    run_seq(0, 25_000_000, 1, 4'h3, 5'h11, 8'h00, 4'h0, 3'd0, 3'd5, 0, 0);
    // R6: two-bit variant, 200 / 100 / other
    run_seq(6, 200_000_000, 1, 4'h7, 5'h02, 8'h00, 4'h9, 3'd4, 3'd1, 0, 0);
    run_seq(9, 100_000_000, 1, 4'h8, 5'h03, 8'h00, 4'h5, 3'd2, 3'd2, 0, 0);
    run_seq(5,  50_000_000, 1, 4'h1, 5'h04, 8'h00, 4'hC, 3'd1, 3'd3, 0, 0);
    // R5: just below the frequency limit, and SDR25 at high speed
    run_seq(5,  49_999_999, 1, 4'h2, 5'h1F, 8'h00, 4'h1, 3'd3, 3'd4, 0, 0);
    run_seq(4, 200_000_000, 1, 4'hF, 5'h0A, 8'h00, 4'h2, 3'd6, 3'd6, 0, 0);
    // R7: wide variant codes, two-bit pair kept
    run_seq(9, 200_000_000, 0, 4'h4, 5'h05, 8'h00, 4'h6, 3'd0, 3'd7, 0, 0);
    run_seq(7,  52_000_000, 0, 4'h5, 5'h06, 8'h00, 4'h3, 3'd2, 3'd0, 0, 0);
    // R4: strobe select in the top mode, both variants, and kept otherwise
    run_seq(10, 200_000_000, 1, 4'h6, 5'h07, 8'hA5, 4'h4, 3'd1, 3'd1, 0, 0);
    run_seq(10, 200_000_000, 0, 4'h6, 5'h07, 8'h3C, 4'h4, 3'd1, 3'd2, 0, 0);
    run_seq(10, 200_000_000, 1, 4'h6, 5'h07, 8'hF7, 4'h4, 3'd1, 3'd3, 0, 0);
    run_seq(9,  200_000_000, 0, 4'h6, 5'h07, 8'hFF, 4'h4, 3'd1, 3'd4, 0, 0);
    // R8: loop never locks, then the flag clears on the next start
    run_seq(9,  200_000_000, 1, 4'h9, 5'h08, 8'h00, 4'hA, 3'd5, 3'd6, 1, 0);
    chk("R8", "sticky error", {31'd0, err_o}, 32'd1);
    run_seq(1,  26_000_000, 1, 4'hA, 5'h09, 8'h00, 4'h0, 3'd0, 3'd2, 0, 0);
    // R8: lock reported late but inside the limit
    run_seq(8,  52_000_000, 0, 4'hB, 5'h0B, 8'h00, 4'h7, 3'd3, 3'd5, 2, 0);
    // R11: start while busy is ignored, both paths
    run_seq(2,  50_000_000, 1, 4'hC, 5'h0C, 8'h00, 4'h0, 3'd0, 3'd1, 0, 1);
    run_seq(6, 100_000_000, 1, 4'hD, 5'h0D, 8'h00, 4'hE, 3'd7, 3'd3, 0, 1);

    repeat (4) @(negedge clk);
    chk("R11", "no pending results", q.size(), 0);
    chk("R11", "idle at end", {31'd0, busy_o}, 32'd0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule